// File: doc/BRIEF.md
# Byte-Addressed I2C Register Target

This block is an I2C target that lets a bus master load and read back a small bank of 8-bit configuration registers. It runs entirely from the system clock. SCL and SDA are synchronized and oversampled, and the block works out the START and STOP conditions and the bit edges from those samples. SDA is driven only as an open-drain pull-down enable. The pad itself and the wired-AND bus sit outside the block.

A write transfer has three parts. The master first sends the device address with the direction bit low. It then sends a register sub-address that loads an internal pointer. Any number of data bytes follow. Each data byte lands in the register the pointer selects, and the pointer then steps forward. After the last register it returns to register 0.

A read transfer starts at the current pointer. Each byte comes out MSB first. The pointer advances after every byte that the master acknowledges. A repeated START is the usual way to join a sub-address write to a read.

There is no valid/ready pairing on the register side. The register file accepts every byte in the same clock cycle that the byte completes, so the block never holds the bus and never needs back-pressure. Every register is always visible on the parallel output.

Top module: `i2c_regwr_target`

## Requirements
- R1: After reset, all ten registers read 0x00, `sda_low_o` is 0 and the pointer selects register 0 as a valid location.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. A START seen at any point, including in the middle of a byte, restarts address reception.
- R3: The block acknowledges the address byte only when its upper seven bits equal 0b001000 followed by `strap_i`. On any other address it does not acknowledge and ignores the bus until the next START or STOP. The acknowledge is SDA held low during the ninth SCL pulse.
- R4: After an address with a write direction bit (bit 0 = 0), the next byte is acknowledged and its low five bits load the pointer.
- R5: Each later byte is acknowledged and written to the register at the pointer. Register i is `regs_o[8*i+7 : 8*i]`. The pointer then increments by one.
- R6: The pointer wraps from 9 back to 0, so a long burst overwrites the lowest registers.
- R7: A sub-address whose top three bits are not all zero, or whose low five bits exceed 9, is still acknowledged. The data bytes that follow it are acknowledged but discarded, and the pointer does not move.
- R8: After an address with a read direction bit (bit 0 = 1), the block shifts out the register at the pointer MSB first. After each byte the master acknowledges, it advances the pointer with the same wrap as R6 and sends the next register.
- R9: When the master does not acknowledge a read byte, SDA is released, the pointer is not advanced and the block ignores the bus until the next START or STOP.
- R10: `sda_low_o` is never set while the master drives a bit. It changes only a few clock cycles after an SCL falling edge, or on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | SCL level as seen at the pad |
| sda_i | input | 1 | SDA level as seen at the pad |
| strap_i | input | 1 | Selects bit 0 of the 7-bit device address |
| sda_low_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| regs_o | output | 80 | All ten registers, register i in bits 8*i+7 down to 8*i |

## Verification
The checker checks the following on every cycle:
- START and STOP are never flagged together.
- A write never targets a location past register 9.
- Each write moves the pointer by exactly one, and a write to register 9 is followed by the pointer at 0.
- The pull-down only switches after an SCL falling edge or a bus condition.
- A STOP always releases SDA.

The remaining behaviour is byte-level and only the bench scenarios can show it:
- Address matching against the strap.
- Acknowledging or discarding data after a bad sub-address.
- Read data order and wrap.
- The pointer holding still after a master NACK.
- Recovery through a repeated START in mid-byte.

// File: rtl/i2c_rw_pkg.sv
package i2c_rw_pkg;
  localparam int BYTE_W = 8;
  localparam logic [5:0] DEV_ADDR_HI = 6'b001000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_WAIT,
    ST_ACK_HOLD,
    ST_TX,
    ST_MACK,
    ST_TX_NEXT
  } bus_st_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_SUB,
    PH_DATA
  } byte_ph_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_rw_pkg::*;
#(
  parameter int NUM_REGS = 10,
  parameter int PTR_W    = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [PTR_W-1:0]           wr_idx,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic [PTR_W-1:0]           rd_idx,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
  logic [BYTE_W-1:0] bank [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank[g] <= '0;
      else if (wr_en && wr_idx == PTR_W'(g))
        bank[g] <= wr_data;
    end
    assign regs_flat[g*BYTE_W +: BYTE_W] = bank[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == PTR_W'(i)) rd_data = bank[i];
  end
endmodule

// File: rtl/i2c_bus_fsm.sv
module i2c_bus_fsm
  import i2c_rw_pkg::*;
#(
  parameter int NUM_REGS = 10,
  parameter int PTR_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_i,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [PTR_W-1:0]  ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_low_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  bus_st_e           st;
  byte_ph_e          ph;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-1:0] sh;
  logic              rw;
  logic              ptr_ok;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic [PTR_W-1:0]  ptr_next;
  logic              byte_done;

  assign rx_byte   = {sh[BYTE_W-2:0], sda_s};
  assign tx_byte   = ptr_ok ? rd_data : '0;
  assign ptr_next  = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign byte_done = (st == ST_RX) && scl_rise && (bit_cnt == 3'd7)
                     && !start_det && !stop_det;
  assign wr_en     = byte_done && (ph == PH_DATA) && ptr_ok;
  assign wr_data   = rx_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph        <= PH_ADDR;
      bit_cnt   <= '0;
      sh        <= '0;
      rw        <= 1'b0;
      ptr       <= '0;
      ptr_ok    <= 1'b1;
      sda_low_o <= 1'b0;
    end else if (start_det) begin
      st        <= ST_RX;
      ph        <= PH_ADDR;
      bit_cnt   <= '0;
      sda_low_o <= 1'b0;
    end else if (stop_det) begin
      st        <= ST_IDLE;
      sda_low_o <= 1'b0;
    end else begin
      case (st)
        ST_RX: if (scl_rise) begin
          sh      <= rx_byte;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            st <= ST_ACK_WAIT;
            case (ph)
              PH_ADDR: begin
                if (rx_byte[BYTE_W-1:1] != {DEV_ADDR_HI, strap_i}) st <= ST_IDLE;
                rw <= rx_byte[0];
              end
              PH_SUB: begin
                ptr    <= rx_byte[PTR_W-1:0];
                ptr_ok <= (rx_byte[BYTE_W-1:PTR_W] == '0) && (rx_byte[PTR_W-1:0] <= LAST);
              end
              default: if (ptr_ok) ptr <= ptr_next;
            endcase
          end
        end
        ST_ACK_WAIT: if (scl_fall) begin
          sda_low_o <= 1'b1;
          st        <= ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (scl_fall) begin
          bit_cnt <= '0;
          if (ph == PH_ADDR && rw) begin
            st        <= ST_TX;
            sh        <= {tx_byte[BYTE_W-2:0], 1'b1};
            sda_low_o <= ~tx_byte[BYTE_W-1];
          end else begin
            st        <= ST_RX;
            sda_low_o <= 1'b0;
            ph        <= (ph == PH_ADDR) ? PH_SUB : PH_DATA;
          end
        end
        ST_TX: if (scl_fall) begin
          if (bit_cnt == 3'd7) begin
            sda_low_o <= 1'b0;
            st        <= ST_MACK;
          end else begin
            sda_low_o <= ~sh[BYTE_W-1];
            sh        <= {sh[BYTE_W-2:0], 1'b1};
            bit_cnt   <= bit_cnt + 3'd1;
          end
        end
        ST_MACK: if (scl_rise) begin
          if (sda_s) st <= ST_IDLE;
          else begin
            st <= ST_TX_NEXT;
            if (ptr_ok) ptr <= ptr_next;
          end
        end
        ST_TX_NEXT: if (scl_fall) begin
          st        <= ST_TX;
          bit_cnt   <= '0;
          sh        <= {tx_byte[BYTE_W-2:0], 1'b1};
          sda_low_o <= ~tx_byte[BYTE_W-1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regwr_target.sv
module i2c_regwr_target
  import i2c_rw_pkg::*;
#(
  parameter int NUM_REGS    = 10,
  parameter int PTR_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic                       strap_i,
  output logic                       sda_low_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_bus_fsm #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .ptr(wr_idx),
    .wr_en(wr_en), .wr_data(wr_data), .sda_low_o(sda_low_o)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(wr_idx), .rd_data(rd_data),
    .regs_flat(regs_o)
  );
endmodule

// File: rtl/i2c_regwr_chk.sv
module i2c_regwr_chk #(
  parameter int PTR_W = 5,
  parameter int LAST  = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_low_o,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic             wr_en,
  input logic [PTR_W-1:0] wr_idx
);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(LAST);

  p_cond_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));

  p_write_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx <= LAST_P);

  p_write_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != LAST_P) |=> wr_idx == $past(wr_idx) + 1'b1);

  p_write_wraps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == LAST_P) |=> wr_idx == '0);

  p_stop_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_low_o);

  p_pull_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low_o) |-> $past(scl_fall));

  p_release_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_low_o) |-> $past(scl_fall || start_det || stop_det));
endmodule

bind i2c_regwr_target i2c_regwr_chk #(.PTR_W(PTR_W), .LAST(NUM_REGS - 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_low_o(sda_low_o), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .wr_en(wr_en), .wr_idx(wr_idx)
);

// File: tb/i2c_regwr_target_test.sv
module i2c_regwr_target_test;
  localparam int NREG = 10;
  localparam int Q    = 10;
  localparam logic [15:0] VEC [8] = '{
    16'h00A5, 16'h093C, 16'h0581, 16'h0A77,
    16'h2311, 16'h02FF, 16'h1F55, 16'h0700
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_low;
  logic [NREG*8-1:0] regs;
  wire sda_line = sda_m & ~sda_low;

  always #4 clk = ~clk;

  i2c_regwr_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .sda_low_o(sda_low), .regs_o(regs)
  );

  int checks = 0, errors = 0;
  logic [7:0] model [NREG];
  logic [4:0] ptr_m = '0;
  bit ok_m = 1'b1, drive_err = 1'b0, a;
  logic [7:0] d;

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [79:0] model_flat();
    logic [79:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic check_regs(input string req);
    chk(regs === model_flat(), req, regs, model_flat());
  endtask

  function automatic void m_sub(input logic [7:0] s);
    ptr_m = s[4:0];
    ok_m  = (s[7:5] == 3'd0) && (s[4:0] <= 5'd9);
  endfunction

  function automatic void m_data(input logic [7:0] v);
    if (ok_m) begin
      model[ptr_m] = v;
      ptr_m = (ptr_m == 5'd9) ? 5'd0 : ptr_m + 5'd1;
    end
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; tick(Q); scl = 1'b1; tick(Q);
    if (sda_low) drive_err = 1'b1;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] v);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl = 1'b1; tick(Q);
      v = {v[6:0], sda_line};
      tick(Q); scl = 1'b0; tick(Q);
    end
    send_bit(!mack);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    tick(10);
    rst_n = 1'b1;
    tick(10);
    // R1: reset state
    check_regs("R1 registers after reset");
    chk(sda_low == 1'b0, "R1 SDA released after reset", sda_low, 0);

    // table of sub-address / data pairs (R4, R5, R7)
    for (int v = 0; v < 8; v++) begin
      bus_start();
      wbyte(8'h20, a); chk(a, "R3 address ack", a, 1);
      wbyte(VEC[v][15:8], a); chk(a, "R4 sub-address acked", a, 1);
      m_sub(VEC[v][15:8]);
      wbyte(VEC[v][7:0], a); chk(a, "R5 data acked", a, 1);
      m_data(VEC[v][7:0]);
      bus_stop();
      check_regs("R5 R7 table write");
    end

    // R6: burst wraps past register 9
    bus_start(); wbyte(8'h20, a); wbyte(8'h08, a); m_sub(8'h08);
    wbyte(8'h11, a); m_data(8'h11);
    wbyte(8'h22, a); m_data(8'h22);
    wbyte(8'h33, a); m_data(8'h33);
    wbyte(8'h44, a); m_data(8'h44);
    bus_stop();
    check_regs("R6 burst wrap");

    // R8: sub-address write, repeated START, read with wrap
    bus_start(); wbyte(8'h20, a); wbyte(8'h08, a);
    bus_start(); wbyte(8'h21, a); chk(a, "R8 read address ack", a, 1);
    rbyte(1'b1, d); chk(d == 8'h11, "R8 read reg8", d, 8'h11);
    rbyte(1'b1, d); chk(d == 8'h22, "R8 read reg9", d, 8'h22);
    rbyte(1'b0, d); chk(d == 8'h33, "R8 read wraps to reg0", d, 8'h33);
    tick(Q);
    chk(sda_low == 1'b0, "R9 SDA released after NACK", sda_low, 0);
    bus_stop();
    // R9: pointer stayed on reg0
    bus_start(); wbyte(8'h21, a);
    rbyte(1'b0, d); chk(d == 8'h33, "R9 no advance on NACK", d, 8'h33);
    bus_stop();

    // R3: address mismatch is ignored
    bus_start();
    wbyte(8'h40, a); chk(!a, "R3 mismatch not acked", a, 0);
    wbyte(8'h01, a); chk(!a, "R3 ignored after mismatch", a, 0);
    wbyte(8'h99, a);
    bus_stop();
    check_regs("R3 mismatch leaves registers");

    // R3: strap selects the address LSB
    strap = 1'b1; tick(Q);
    bus_start(); wbyte(8'h20, a); chk(!a, "R3 strap=1 rejects 0x20", a, 0); bus_stop();
    bus_start(); wbyte(8'h22, a); chk(a, "R3 strap=1 accepts 0x22", a, 1);
    wbyte(8'h04, a); m_sub(8'h04); wbyte(8'h5A, a); m_data(8'h5A);
    bus_stop();
    check_regs("R3 strap write");
    strap = 1'b0; tick(Q);

    // R2: repeated START mid-byte restarts address reception
    bus_start(); wbyte(8'h20, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start(); wbyte(8'h20, a); chk(a, "R2 address after repeated START", a, 1);
    wbyte(8'h06, a); m_sub(8'h06); wbyte(8'h66, a); m_data(8'h66);
    bus_stop();
    check_regs("R2 write after restart");

    // R7: invalid sub-address burst is acked and dropped
    bus_start(); wbyte(8'h20, a);
    wbyte(8'h0C, a); chk(a, "R7 bad sub-address acked", a, 1); m_sub(8'h0C);
    wbyte(8'h01, a); chk(a, "R7 discarded data acked", a, 1); m_data(8'h01);
    wbyte(8'h02, a); m_data(8'h02);
    bus_stop();
    check_regs("R7 data discarded");

    chk(!drive_err, "R10 no pull-down during master bits", drive_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule